// File: doc/BRIEF.md
# Pipelined Times-Three Datapath

This block is a streaming arithmetic unit. It takes one unsigned 32-bit operand per clock and returns three times that operand. It uses two adders and no multiplier. The first adder doubles the operand. The second adder adds the original operand back to that doubled value. A delayed copy of the operand moves down the pipe next to the doubled value, so the second adder always sees the operand that matches the partial sum in front of it.

A parameter selects how deep the pipe is. The shallow build gives each adder one register stage, so results appear two cycles after the operand. The deep build cuts each adder at its midpoint. The lower half and its carry-out are registered first, and the upper half is finished in the following stage, which gives a four-cycle latency. Both builds accept a new operand every cycle. A valid flag travels with each operand, and there is no backpressure.

Top module: `tri_mul3`

## Requirements
- R1: Whenever `out_valid` is high, `out_result` equals exactly 3 × A, zero-extended to 34 bits, where A is the operand that was accepted with `in_valid` high.
- R2: The delay from an operand being sampled with `in_valid` high to the matching `out_valid` pulse is 2 cycles when `DEPTH` is 0 (shallow) and 4 cycles when `DEPTH` is 1 (deep).
- R3: Operands presented on consecutive cycles each produce one result, on consecutive cycles and in the order they arrived.
- R4: A cycle with `in_valid` low produces no result: `out_valid` is low exactly one latency later. The value on `in_a` in that cycle does not affect any result.
- R5: While `rst` is high, `out_valid` is low. Operands already in flight when reset is sampled are dropped. `out_valid` stays low for the first latency cycles after reset is released, and reset does not clear the data registers.
- R6: In the deep build each adder is split at bit 16. A carry out of the lower half reaches the upper half one stage later, so operands such as 0x0000FFFF (result 0x2FFFD) and 0x00008000 (result 0x18000) give exact results.
- R7: The extreme operands give exact results: A = 0 gives 0, and A = 0xFFFFFFFF gives 0x2FFFFFFFD with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Operand on `in_a` is to be processed this cycle |
| in_a | input | 32 | Unsigned operand |
| out_valid | output | 1 | `out_result` carries a finished product |
| out_result | output | 34 | Three times the operand |

## Verification
The properties assume that `rst` is high at the first clock edge, because the valid flags have no defined value before that. They also assume that the operand is stable when it is sampled with `in_valid` high. A counter that starts at reset keeps the latency properties from looking back past the most recent reset. The stimulus holds reset high for its first cycles and drives inputs only on falling edges. It mixes a seeded random stream with random valid gaps, directed carry-boundary and extreme operands, and a reset issued in the middle of a stream. Both depth builds receive the same stimulus side by side.

// File: rtl/tri_mul3_pkg.sv
package tri_mul3_pkg;

    // Pipeline depth selector: one register stage per adder, or two.
    typedef enum logic {
        PIPE_SHALLOW = 1'b0,
        PIPE_DEEP    = 1'b1
    } pipe_depth_e;

    localparam int unsigned DEF_A_W = 32;

    // Register stages taken by a single adder in the given build.
    function automatic int unsigned add_lat(pipe_depth_e d);
        return (d == PIPE_DEEP) ? 2 : 1;
    endfunction

    // Bit position where a deep adder is cut.
    function automatic int unsigned cut_point(int unsigned w);
        return w / 2;
    endfunction

endpackage

// File: rtl/tri_reg_slice.sv
module tri_reg_slice #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Data register without reset; the valid flags carry meaning.
    always_ff @(posedge clk) begin
        if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/tri_add_stage.sv
module tri_add_stage
    import tri_mul3_pkg::*;
#(
    parameter int unsigned W     = 34,
    parameter pipe_depth_e DEPTH = PIPE_DEEP,
    parameter int unsigned LO_W  = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic         out_vld,
    output logic [W-1:0] sum
);

    localparam int unsigned HI_W = W - LO_W;

    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic            cy;
        logic [HI_W-1:0] xh;
        logic [HI_W-1:0] yh;
    } half_t;

    localparam int unsigned HALF_BITS = $bits(half_t);

    generate
        if (DEPTH == PIPE_DEEP) begin : g_split
            logic [LO_W:0]      lo_full;
            half_t              h_d;
            logic [HALF_BITS-1:0] h_q_bits;
            half_t              h_q;
            logic               v_mid;
            logic               v_end;
            logic [HI_W-1:0]    hi_sum;
            logic [W-1:0]       fin_d;

            // First half: lower bits and their carry, upper operands carried along.
            always_comb begin
                lo_full = {1'b0, x[LO_W-1:0]} + {1'b0, y[LO_W-1:0]};
                h_d.lo  = lo_full[LO_W-1:0];
                h_d.cy  = lo_full[LO_W];
                h_d.xh  = x[W-1:LO_W];
                h_d.yh  = y[W-1:LO_W];
            end

            tri_reg_slice #(.W(HALF_BITS)) u_mid (
                .clk (clk),
                .en  (in_vld),
                .d   (h_d),
                .q   (h_q_bits)
            );

            assign h_q = half_t'(h_q_bits);

            // Second half: upper bits plus the registered carry.
            always_comb begin
                hi_sum = h_q.xh + h_q.yh + HI_W'(h_q.cy);
                fin_d  = {hi_sum, h_q.lo};
            end

            tri_reg_slice #(.W(W)) u_end (
                .clk (clk),
                .en  (v_mid),
                .d   (fin_d),
                .q   (sum)
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    v_mid <= 1'b0;
                    v_end <= 1'b0;
                end else begin
                    v_mid <= in_vld;
                    v_end <= v_mid;
                end
            end

            assign out_vld = v_end;
        end else begin : g_flat
            logic [W-1:0] full;
            logic         v_q;

            assign full = x + y;

            tri_reg_slice #(.W(W)) u_one (
                .clk (clk),
                .en  (in_vld),
                .d   (full),
                .q   (sum)
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= 1'b0;
                end else begin
                    v_q <= in_vld;
                end
            end

            assign out_vld = v_q;
        end
    endgenerate

endmodule

// File: rtl/tri_mul3.sv
module tri_mul3
    import tri_mul3_pkg::*;
#(
    parameter int unsigned A_W   = DEF_A_W,
    parameter pipe_depth_e DEPTH = PIPE_DEEP
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [A_W-1:0] in_a,
    output logic           out_valid,
    output logic [A_W+1:0] out_result
);

    localparam int unsigned R_W  = A_W + 2;
    localparam int unsigned S1_W = A_W + 1;
    localparam int unsigned LO_W = cut_point(A_W);
    localparam int unsigned STG  = add_lat(DEPTH);
    localparam int unsigned LAT  = 2 * STG;

    logic            dbl_vld;
    logic [S1_W-1:0] dbl_sum;
    logic [A_W-1:0]  a_pipe [STG+1];

    // First adder: A + A.
    tri_add_stage #(
        .W     (S1_W),
        .DEPTH (DEPTH),
        .LO_W  (LO_W)
    ) u_dbl (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_valid),
        .x       ({1'b0, in_a}),
        .y       ({1'b0, in_a}),
        .out_vld (dbl_vld),
        .sum     (dbl_sum)
    );

    // Operand copy delayed to line up with the doubled value.
    assign a_pipe[0] = in_a;

    generate
        for (genvar i = 0; i < STG; i++) begin : g_a_dly
            tri_reg_slice #(.W(A_W)) u_a (
                .clk (clk),
                .en  (1'b1),
                .d   (a_pipe[i]),
                .q   (a_pipe[i+1])
            );
        end
    endgenerate

    // Second adder: 2A + A.
    tri_add_stage #(
        .W     (R_W),
        .DEPTH (DEPTH),
        .LO_W  (LO_W)
    ) u_tri (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (dbl_vld),
        .x       ({1'b0, dbl_sum}),
        .y       ({2'b00, a_pipe[STG]}),
        .out_vld (out_valid),
        .sum     (out_result)
    );

endmodule

// File: rtl/tri_mul3_chk.sv
module tri_mul3_chk #(
    parameter int unsigned A_W = 32,
    parameter int unsigned LAT = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [A_W-1:0] in_a,
    input logic           out_valid,
    input logic [A_W+1:0] out_result
);

    localparam int unsigned R_W = A_W + 2;
    localparam int unsigned CW  = $clog2(LAT + 1) + 1;

    // Cycles since reset, saturating at the latency.
    logic [CW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst < CW'(LAT)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    a_r1_triple: assert property (@(posedge clk) disable iff (rst)
        (since_rst == CW'(LAT) && out_valid) |->
            (out_result == R_W'(R_W'($past(in_a, LAT)) * R_W'(3))));

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst == CW'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    a_r4_bubble: assert property (@(posedge clk) disable iff (rst)
        (since_rst == CW'(LAT) && !$past(in_valid, LAT)) |-> !out_valid);

    a_r5_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    a_r5_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        (since_rst < CW'(LAT)) |-> !out_valid);

endmodule

bind tri_mul3 tri_mul3_chk #(
    .A_W (A_W),
    .LAT (LAT)
) u_tri_mul3_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_a       (in_a),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/test_tri_mul3.sv
module test_tri_mul3;
    import tri_mul3_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LAT_S      = 2;
    localparam int LAT_D      = 4;

    logic        clk      = 1'b0;
    logic        rst      = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_a     = '0;
    logic        vs, vd;
    logic [33:0] rs, rd;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_req  = "R5";

    bit          hv [8];
    logic [31:0] ha [8];
    bit          hr [8];
    int unsigned k = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tri_mul3 #(.A_W(32), .DEPTH(PIPE_SHALLOW)) i_tri_mul3 (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_a (in_a),
        .out_valid (vs), .out_result (rs)
    );

    tri_mul3 #(.A_W(32), .DEPTH(PIPE_DEEP)) i_tri_mul3_deep (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_a (in_a),
        .out_valid (vd), .out_result (rd)
    );

    function automatic logic [33:0] times3(logic [31:0] a);
        return 34'(a) * 34'd3;
    endfunction

    // Expected output from the drive history: valid if driven valid LAT
    // steps ago and no reset was driven in the window since.
    task automatic check_one(string dut, int lat, logic v, logic [33:0] r);
        bit          ev = 1'b0;
        logic [33:0] er = '0;
        if (k >= lat) begin
            ev = hv[(k - lat) % 8];
            for (int j = 1; j <= lat; j++) begin
                if (hr[(k - j) % 8]) ev = 1'b0;
            end
            er = times3(ha[(k - lat) % 8]);
        end
        n_checks++;
        if (v !== ev || (ev && r !== er)) begin
            n_fail++;
            $display("FAIL %s %s: got valid=%0b result=%0h, expected valid=%0b result=%0h",
                     cur_req, dut, v, r, ev, er);
        end
    endtask

    task automatic step(bit v, logic [31:0] a, bit r);
        @(negedge clk);
        check_one("shallow", LAT_S, vs, rs);
        check_one("deep", LAT_D, vd, rd);
        hv[k % 8] = v;
        ha[k % 8] = a;
        hr[k % 8] = r;
        in_valid  = v;
        in_a      = a;
        rst       = r;
        k++;
    endtask

    initial begin
        logic [31:0] doc_seq [5];
        logic [31:0] carry_seq [6];
        doc_seq   = '{32'd7, 32'd17, 32'd4, 32'd1, 32'd23};
        carry_seq = '{32'h0000FFFF, 32'h00008000, 32'h0001FFFF,
                      32'h7FFFFFFF, 32'hFFFF0000, 32'h0000C000};
        for (int i = 0; i < 8; i++) begin
            hv[i] = 1'b0; ha[i] = '0; hr[i] = 1'b1;
        end
        void'($urandom(32'h5EED_0003));

        // R5: operands offered while reset is high must not emerge
        cur_req = "R5";
        repeat (3) step(1'b1, $urandom, 1'b1);
        step(1'b0, 32'd0, 1'b0);

        // R1: the basic stream 7, 17, 4, 1, 23 gives 21, 51, 12, 3, 69
        cur_req = "R1";
        foreach (doc_seq[i]) step(1'b1, doc_seq[i], 1'b0);

        // R7: extreme operands
        cur_req = "R7";
        step(1'b1, 32'd0, 1'b0);
        step(1'b1, 32'hFFFFFFFF, 1'b0);
        step(1'b1, 32'd0, 1'b0);

        // R6: carries across the deep cut at bit 16
        cur_req = "R6";
        foreach (carry_seq[i]) step(1'b1, carry_seq[i], 1'b0);

        // R3: long back-to-back random stream
        cur_req = "R3";
        repeat (64) step(1'b1, $urandom, 1'b0);

        // R4: random gaps; operand lines change while invalid
        cur_req = "R4";
        repeat (1500) step(($urandom % 2) == 0, $urandom, 1'b0);

        // R2: isolated operand, then idle
        cur_req = "R2";
        step(1'b1, $urandom, 1'b0);
        repeat (6) step(1'b0, $urandom, 1'b0);

        // R5: reset in the middle of a stream drops what is in flight
        cur_req = "R5";
        repeat (5) step(1'b1, $urandom, 1'b0);
        step(1'b1, $urandom, 1'b1);
        repeat (8) step(1'b1, $urandom, 1'b0);

        cur_req = "R2";
        repeat (6) step(1'b0, 32'd0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog %s: got running, expected finished", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule